// File: doc/BRIEF.md
# Parallel RGB Panel Raster Timing Generator

This block scans a parallel RGB panel. It keeps a horizontal and a vertical position counter that advance on a single pixel-clock enable. From these counters it derives the line sync, the frame sync, data-enable and the raw scan position. Start-of-frame and end-of-frame pulses mark the frame boundaries. Pixel fetch, colour formatting and clock generation belong to neighbouring blocks.

A narrow register write port programs the timing. All points in a line or frame are absolute counts measured from the leading edge of sync:
- the sync widths;
- the active window's first and past-the-end counts, where first = sync width + back porch and end = first + active size;
- the totals, where total = end + front porch.

Polarity bits invert each output. A further flag tells the output stage to launch data on the falling pixel-clock edge. A start command begins scanning. A stop request lets the current frame finish, then parks the outputs and raises a stopped flag. Software must clear that flag before it can start the block again.

Top module: `lcd_raster_timer`

## Requirements
- R1: After reset:
  - `running` and `stopped` are 0;
  - `hsync`, `vsync` and `de` are 0;
  - `h_pos` and `v_pos` are 0.
- R2: While running, `h_pos` counts from 0 to htotal-1 and advances only in cycles with `pix_en` high. When it wraps, `v_pos` increments. `v_pos` wraps to 0 after vtotal-1.
- R3: Line sync is active while `h_pos` < hsync width. Frame sync is active while `v_pos` < vsync width. Both are inactive when not running.
- R4: Data-enable is active only when running, hstart <= `h_pos` < hend and vstart <= `v_pos` < vend.
- R5: Configuration register (address 0) polarity bits:
  - bit 0 inverts `hsync`, bit 1 inverts `vsync`, bit 2 inverts `de`;
  - bit 3 is presented on `pclk_fall`.
- R6: Register layout:
  - address 1 holds the hsync width in bits 9:0;
  - address 2 holds the vsync width in bits 9:0;
  - address 3 holds htotal in bits 31:16 and vtotal in bits 15:0;
  - addresses 4 and 5 hold the horizontal and vertical window, start in bits 31:16 and end in bits 15:0.
- R7: Widths, windows and totals are captured at start and at each frame wrap. Writes in mid-frame take effect from the next frame.
- R8: `sof` pulses in a `pix_en` cycle at position (0,0) when configuration bit 4 is set. `eof` pulses in a `pix_en` cycle at the last pixel of the frame when configuration bit 5 is set.
- R9: Writing bit 1 at address 6 while running lets the current frame complete. After the frame completes:
  - `running` falls;
  - `stopped` rises;
  - the counters return to 0;
  - the outputs go inactive.
- R10: A start command (bit 0 at address 6) is ignored while `stopped` is set. Any write to address 7 clears `stopped`.
- R11: A start command while running has no effect on the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pix_en | input | 1 | Pixel-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Line sync, polarity applied |
| vsync | output | 1 | Frame sync, polarity applied |
| de | output | 1 | Data-enable, polarity applied |
| pclk_fall | output | 1 | Falling-edge launch flag |
| sof | output | 1 | Start-of-frame pulse |
| eof | output | 1 | End-of-frame pulse |
| running | output | 1 | Scanning active |
| stopped | output | 1 | Stopped status flag |
| h_pos | output | TW | Horizontal count |
| v_pos | output | TW | Vertical count |

## Verification
The bench builds the block with its default parameters: 16-bit counts and 10-bit sync widths. It then programs a tiny raster of 9 by 6 counts, later 7 by 4. With frames this small, every pixel of several whole frames is compared against arithmetic expectations. Those frames cover all polarity settings and a gapped `pix_en` pattern. They also reach a mid-frame reprogramming and the full stop, blocked-start and clear sequence within a few hundred cycles.

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer #(
  parameter int TW = 16,
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pclk_fall,
  output logic          sof,
  output logic          eof,
  output logic          running,
  output logic          stopped,
  output logic [TW-1:0] h_pos,
  output logic [TW-1:0] v_pos
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [5:0]    cfg;
  logic [SW-1:0] hsw_r, vsw_r, hsw_s, vsw_s;
  logic [TW-1:0] ht_r, vt_r, hds_r, hde_r, vds_r, vde_r;
  logic [TW-1:0] ht_s, vt_s, hds_s, hde_s, vds_s, vde_s;
  logic [TW-1:0] hcnt, vcnt;
  logic          run, stop_req, done;

  logic ctrl_wr, start_cmd, line_end, last_px, load;
  assign ctrl_wr   = wr_en && wr_addr == 3'd6;
  assign start_cmd = ctrl_wr && wr_data[0] && !run && !done;
  assign line_end  = hcnt == ht_s - ONE;
  assign last_px   = line_end && vcnt == vt_s - ONE;
  assign load      = start_cmd || (run && pix_en && last_px && !stop_req);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg <= '0; hsw_r <= '0; vsw_r <= '0;
      ht_r <= '0; vt_r <= '0; hds_r <= '0; hde_r <= '0; vds_r <= '0; vde_r <= '0;
    end else if (wr_en)
      case (wr_addr)
        3'd0: cfg <= wr_data[5:0];
        3'd1: hsw_r <= wr_data[SW-1:0];
        3'd2: vsw_r <= wr_data[SW-1:0];
        3'd3: begin ht_r <= wr_data[16 +: TW]; vt_r <= wr_data[0 +: TW]; end
        3'd4: begin hds_r <= wr_data[16 +: TW]; hde_r <= wr_data[0 +: TW]; end
        3'd5: begin vds_r <= wr_data[16 +: TW]; vde_r <= wr_data[0 +: TW]; end
        default: ;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hsw_s <= '0; vsw_s <= '0;
      ht_s <= '0; vt_s <= '0; hds_s <= '0; hde_s <= '0; vds_s <= '0; vde_s <= '0;
    end else if (load) begin
      hsw_s <= hsw_r; vsw_s <= vsw_r;
      ht_s <= ht_r; vt_s <= vt_r; hds_s <= hds_r; hde_s <= hde_r; vds_s <= vds_r; vde_s <= vde_r;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0; done <= 1'b0; stop_req <= 1'b0; hcnt <= '0; vcnt <= '0;
    end else begin
      if (run && pix_en) begin
        if (last_px) begin
          hcnt <= '0;
          vcnt <= '0;
          if (stop_req) begin
            run <= 1'b0; done <= 1'b1; stop_req <= 1'b0;
          end
        end else if (line_end) begin
          hcnt <= '0;
          vcnt <= vcnt + ONE;
        end else
          hcnt <= hcnt + ONE;
      end
      if (start_cmd) begin
        run <= 1'b1; stop_req <= 1'b0; hcnt <= '0; vcnt <= '0;
      end
      if (ctrl_wr && wr_data[1] && run && !(pix_en && last_px)) stop_req <= 1'b1;
      if (wr_en && wr_addr == 3'd7) done <= 1'b0;
    end

  logic hs_a, vs_a, de_a;
  assign hs_a = run && hcnt < TW'(hsw_s);
  assign vs_a = run && vcnt < TW'(vsw_s);
  assign de_a = run && hcnt >= hds_s && hcnt < hde_s && vcnt >= vds_s && vcnt < vde_s;

  assign hsync     = hs_a ^ cfg[0];
  assign vsync     = vs_a ^ cfg[1];
  assign de        = de_a ^ cfg[2];
  assign pclk_fall = cfg[3];
  assign sof       = run && pix_en && hcnt == '0 && vcnt == '0 && cfg[4];
  assign eof       = run && pix_en && last_px && cfg[5];
  assign running   = run;
  assign stopped   = done;
  assign h_pos     = hcnt;
  assign v_pos     = vcnt;
endmodule

// File: rtl/lcd_raster_timer_chk.sv
module lcd_raster_timer_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic          run,
  input logic          stopped,
  input logic [TW-1:0] hcnt,
  input logic [TW-1:0] vcnt,
  input logic [TW-1:0] ht_s
);
  a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    run && !pix_en |=> $stable(hcnt) && $stable(vcnt));

  a_r2_h_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run && ht_s != '0 |-> hcnt < ht_s);

  a_r9_stop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $rose(stopped) && hcnt == '0 && vcnt == '0);

  a_r10_blocked_while_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    stopped && !run && !(wr_en && wr_addr == 3'd7) |=> !run);

  a_r7_capture_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ht_s) |-> hcnt == '0 && vcnt == '0);
endmodule

bind lcd_raster_timer lcd_raster_timer_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .run(running), .stopped(stopped), .hcnt(h_pos), .vcnt(v_pos), .ht_s(ht_s)
);

// File: tb/lcd_raster_timer_bench.sv
module lcd_raster_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, pix_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic hsync, vsync, de, pclk_fall, sof, eof, running, stopped;
  logic [15:0] h_pos, v_pos;

  always #5 clk = ~clk;

  lcd_raster_timer u_lcd_raster_timer (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de), .pclk_fall(pclk_fall),
    .sof(sof), .eof(eof), .running(running), .stopped(stopped), .h_pos(h_pos), .v_pos(v_pos));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // programmed and captured timing, in counts
  int r_hsw, r_vsw, r_ht, r_vt, r_hds, r_hde, r_vds, r_vde;
  int c_hsw, c_vsw, c_ht, c_vt, c_hds, c_hde, c_vds, c_vde;
  int m_h, m_v;
  bit m_run, m_stp, m_sreq;
  logic [5:0] m_cfg;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit last_px();
    return m_h == c_ht - 1 && m_v == c_vt - 1;
  endfunction

  task automatic capture();
    c_hsw = r_hsw; c_vsw = r_vsw; c_ht = r_ht; c_vt = r_vt;
    c_hds = r_hds; c_hde = r_hde; c_vds = r_vds; c_vde = r_vde;
  endtask

  // compare every output against the arithmetic expectation (pix_en already set)
  task automatic check_all();
    bit hs, vs, da;
    hs = m_run && m_h < c_hsw;
    vs = m_run && m_v < c_vsw;
    da = m_run && m_h >= c_hds && m_h < c_hde && m_v >= c_vds && m_v < c_vde;
    chk("R2", "h_pos", 32'(h_pos), 32'(m_h));
    chk("R2", "v_pos", 32'(v_pos), 32'(m_v));
    chk("R3 R5", "hsync", 32'(hsync), 32'(hs ^ m_cfg[0]));
    chk("R3 R5", "vsync", 32'(vsync), 32'(vs ^ m_cfg[1]));
    chk("R4 R5", "de", 32'(de), 32'(da ^ m_cfg[2]));
    chk("R5", "pclk_fall", 32'(pclk_fall), 32'(m_cfg[3]));
    chk("R8", "sof", 32'(sof), 32'(m_run && pix_en && m_h == 0 && m_v == 0 && m_cfg[4]));
    chk("R8", "eof", 32'(eof), 32'(m_run && pix_en && last_px() && m_cfg[5]));
    chk("R9", "running", 32'(running), 32'(m_run));
    chk("R10", "stopped", 32'(stopped), 32'(m_stp));
  endtask

  task automatic cyc(bit pe);
    pix_en = pe;
    #1;
    check_all();
    @(posedge clk);
    if (m_run && pe) begin
      if (last_px()) begin
        m_h = 0; m_v = 0;
        if (m_sreq) begin m_run = 0; m_stp = 1; m_sreq = 0; end
        else capture();
      end else if (m_h == c_ht - 1) begin
        m_h = 0; m_v++;
      end else m_h++;
    end
    @(negedge clk);
  endtask

  // R6 field layout: widths in 9:0, totals/windows upper half first count, lower half second
  task automatic wr(logic [2:0] a, logic [31:0] d);
    pix_en = 0; wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    case (a)
      3'd0: m_cfg = d[5:0];
      3'd1: r_hsw = int'(d[9:0]);
      3'd2: r_vsw = int'(d[9:0]);
      3'd3: begin r_ht = int'(d[31:16]); r_vt = int'(d[15:0]); end
      3'd4: begin r_hds = int'(d[31:16]); r_hde = int'(d[15:0]); end
      3'd5: begin r_vds = int'(d[31:16]); r_vde = int'(d[15:0]); end
      3'd6: begin
        if (d[0] && !m_run && !m_stp) begin m_run = 1; m_h = 0; m_v = 0; m_sreq = 0; capture(); end
        if (d[1] && m_run) m_sreq = 1;
      end
      default: m_stp = 0;
    endcase
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_run = 0; m_stp = 0; m_sreq = 0; m_cfg = '0; m_h = 0; m_v = 0;
    r_hsw = 0; r_vsw = 0; r_ht = 0; r_vt = 0; r_hds = 0; r_hde = 0; r_vds = 0; r_vde = 0;
    capture();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "running", 32'(running), 0);
    chk("R1", "stopped", 32'(stopped), 0);
    chk("R1", "hsync", 32'(hsync), 0);
    chk("R1", "vsync", 32'(vsync), 0);
    chk("R1", "de", 32'(de), 0);
    chk("R1", "pos", {h_pos, v_pos}, 0);
    rst_n = 1;
    @(negedge clk);

    // R6 program a 9x6 raster
    wr(3'd1, 32'h0000_0002);
    wr(3'd2, 32'h0000_0001);
    wr(3'd3, {16'd9, 16'd6});
    wr(3'd4, {16'd3, 16'd7});
    wr(3'd5, {16'd2, 16'd5});
    wr(3'd0, 32'h0000_0030);
    wr(3'd6, 32'h1);
    for (int i = 0; i < 2 * 54; i++) cyc(1);

    // R5 all polarities inverted, gapped pix_en
    wr(3'd0, 32'h0000_003F);
    for (int i = 0; i < 90; i++) cyc(i % 3 != 0);

    // R7 mid-frame reprogramming to a 7x4 raster
    for (int i = 0; i < 20; i++) cyc(1);
    wr(3'd3, {16'd7, 16'd4});
    wr(3'd4, {16'd2, 16'd5});
    wr(3'd5, {16'd1, 16'd3});
    wr(3'd1, 32'h0000_0001);
    wr(3'd0, 32'h0000_0030);
    for (int i = 0; i < 34 + 2 * 28; i++) cyc(1);
    chk("R7", "h_total_applied", 32'(c_ht), 7);

    // R11 start while running leaves counters alone
    for (int i = 0; i < 5; i++) cyc(1);
    wr(3'd6, 32'h1);
    chk("R11", "h_pos", 32'(h_pos), 32'(m_h));
    chk("R11", "v_pos", 32'(v_pos), 32'(m_v));
    for (int i = 0; i < 4; i++) cyc(1);

    // R9 graceful stop
    wr(3'd6, 32'h2);
    for (int i = 0; i < 200 && m_run; i++) cyc(i % 4 != 1);
    chk("R9", "stopped_after_frame", 32'(stopped), 1);
    for (int i = 0; i < 6; i++) cyc(1);

    // R10 start blocked while stopped, then clear and start
    wr(3'd6, 32'h1);
    chk("R10", "blocked_start", 32'(running), 0);
    for (int i = 0; i < 4; i++) cyc(1);
    wr(3'd7, 32'h0);
    chk("R10", "cleared", 32'(stopped), 0);
    wr(3'd6, 32'h1);
    chk("R10", "restart", 32'(running), 1);
    for (int i = 0; i < 40; i++) cyc(1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule